// File: doc/BRIEF.md
# Flash Write-Status Reporter

This block sits on the device side of a flash memory and reports the progress of an internal program or erase operation to a host that polls the read data bus. When the command decoder has accepted the final write strobe of a program or erase sequence, it pulses a start input together with the operation type and the word being written. From that point the block owns data lines 7 and 6 and an open-drain ready/busy output until the internal operation is finished. An internal cycle timer stands in for the real program and erase durations, and a second timed phase holds off true array data for a bus-recovery interval after completion.

Two polling methods work at the same time. On data line 7 a program shows the complement of the bit being written and an erase shows zero. Both return to the final value when the operation completes. On data line 6 every qualified read returns the opposite of the previous one while the operation runs. A host can therefore detect completion either by comparing bit 7 or by watching bit 6 stop changing. The ready/busy output is a pull-low enable that is active only while an operation runs, chip-enable is low and reset is high.

The controller has four states:
- `ST_IDLE`: array data passes through.
- `ST_PROG` and `ST_ERASE`: busy.
- `ST_RECOV`: bus recovery.

The transitions are:
- start accepted: `ST_IDLE` to `ST_PROG` or `ST_ERASE`.
- timer expiry: `ST_PROG` or `ST_ERASE` to `ST_RECOV`.
- timer expiry: `ST_RECOV` to `ST_IDLE`.
- reset low: any state to `ST_IDLE`.

Top module: `flash_wstat`

## Requirements
- R1: While reset is low and right after it is released, the block is idle. The ready/busy pull-low is inactive and, with chip-enable and output-enable low after release, `dq_out` equals `arr_data`.
- R2: During a program, a read shows the complement of bit 7 of the programmed word on bit 7. Every bit other than 7 and 6 reads as 0.
- R3: During an erase, bit 7 reads as 0. Every bit other than 7 and 6 reads as 0.
- R4: During program or erase, each read (read strobe with chip-enable and output-enable low) returns on bit 6 the inverse of the previous read's bit 6. Cycles without a read leave bit 6 unchanged.
- R5: Once the operation completes, bit 6 stops changing, even on reads. Bit 7 shows the true bit 7 of the programmed word after a program, or 1 after an erase.
- R6: The ready/busy pull-low is active from the first cycle after an accepted start to the end of the busy phase. It is released in any cycle with chip-enable high.
- R7: A program stays busy for exactly `PROG_CYC` cycles and an erase for exactly `ERASE_CYC` cycles.
- R8: After completion, status (not array data) is presented for exactly `RECOV_CYC` cycles. After that, `dq_out` follows `arr_data`.
- R9: A start pulse is ignored during the busy phase and during the recovery phase, including the last recovery cycle.
- R10: Reset low aborts a running operation at once. The pull-low and the output enable go inactive, the toggle bit clears, and array data returns after release.
- R11: `dq_oe` is high only when chip-enable and output-enable are both low and reset is high. When `dq_oe` is low, `dq_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low reset, asynchronous, aborts any operation |
| op_start | input | 1 | One-cycle pulse: final write strobe of a command accepted |
| op_is_erase | input | 1 | Operation type at start: 1 erase, 0 program |
| op_word | input | DW | Word being programmed, sampled at start |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_stb | input | 1 | One-cycle read strobe |
| arr_data | input | DW | True array data for the addressed word |
| dq_out | output | DW | Read data bus value |
| dq_oe | output | 1 | Read data bus drive enable |
| rb_pull_low | output | 1 | Ready/busy open-drain pull-low enable |

## Verification
A read strobe can fall in the last busy cycle, the same cycle in which the timer ends the operation. The bench places a read exactly there. It then expects the toggle bit to have flipped once and to hold its value through every later read in recovery, while bit 7 has already switched to its final value. A start pulse can also coincide with the final recovery cycle. The bench drives one there and expects plain array data with no pull-low on the following cycles.

// File: rtl/fws_pkg.sv
package fws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2,
        ST_RECOV = 2'd3
    } fws_state_t;
endpackage

// File: rtl/fws_timer.sv
// Down-counter shared by the busy and recovery phases.
module fws_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fws_toggle.sv
// Toggle status bit: flips once per qualified read while busy.
module fws_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic tgl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tgl <= 1'b0;
        else if (advance) tgl <= ~tgl;
    end
endmodule

// File: rtl/fws_outmux.sv
// Output process: data bus selection, bus enable and ready/busy drive.
module fws_outmux
    import fws_pkg::*;
#(
    parameter int DW = 16
) (
    input  fws_state_t    state,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          w7_q,
    input  logic          tgl,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          rb_pull_low
);
    logic [DW-1:0] sel;

    always_comb begin
        sel = '0;
        unique case (state)
            ST_IDLE:  sel = arr_data;
            ST_PROG:  begin sel[7] = ~w7_q; sel[6] = tgl; end
            ST_ERASE: begin sel[7] = 1'b0;  sel[6] = tgl; end
            ST_RECOV: begin sel[7] = w7_q;  sel[6] = tgl; end
            default:  sel = '0;
        endcase
        dq_oe       = rst_n && !ce_n && !oe_n;
        dq_out      = dq_oe ? sel : '0;
        rb_pull_low = rst_n && !ce_n && (state == ST_PROG || state == ST_ERASE);
    end
endmodule

// File: rtl/flash_wstat.sv
module flash_wstat
    import fws_pkg::*;
#(
    parameter int DW        = 16,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 60,
    parameter int RECOV_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic          op_is_erase,
    input  logic [DW-1:0] op_word,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          rd_stb,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          rb_pull_low
);
    localparam int MAXC_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAXC   = (MAXC_A > RECOV_CYC) ? MAXC_A : RECOV_CYC;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PROG_LD  = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] ERASE_LD = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] RECOV_LD = CW'(RECOV_CYC - 1);

    fws_state_t    state_q, state_d;
    logic          expired, busy, start_ok, tmr_load, rd_q, tgl_q;
    logic          w7_q, w7_d;
    logic [CW-1:0] tmr_val;

    assign busy     = (state_q == ST_PROG) || (state_q == ST_ERASE);
    assign start_ok = (state_q == ST_IDLE) && op_start;
    assign rd_q     = rd_stb && !ce_n && !oe_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            w7_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            w7_q    <= w7_d;
        end
    end

    // Next-state and timer control
    always_comb begin
        state_d  = state_q;
        w7_d     = w7_q;
        tmr_load = 1'b0;
        tmr_val  = RECOV_LD;
        unique case (state_q)
            ST_IDLE: if (op_start) begin
                tmr_load = 1'b1;
                if (op_is_erase) begin
                    state_d = ST_ERASE;
                    tmr_val = ERASE_LD;
                    w7_d    = 1'b1;
                end else begin
                    state_d = ST_PROG;
                    tmr_val = PROG_LD;
                    w7_d    = op_word[7];
                end
            end
            ST_PROG, ST_ERASE: if (expired) begin
                state_d  = ST_RECOV;
                tmr_load = 1'b1;
                tmr_val  = RECOV_LD;
            end
            ST_RECOV: if (expired) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    fws_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    fws_toggle u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (busy && rd_q),
        .tgl     (tgl_q)
    );

    fws_outmux #(.DW(DW)) u_out (
        .state       (state_q),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .w7_q        (w7_q),
        .tgl         (tgl_q),
        .arr_data    (arr_data),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe),
        .rb_pull_low (rb_pull_low)
    );

    logic unused_ok;
    assign unused_ok = start_ok;
endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk
    import fws_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_start,
    input logic          ce_n,
    input logic          oe_n,
    input logic          rd_stb,
    input fws_state_t    state_q,
    input logic          tgl_q,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe,
    input logic          rb_pull_low
);
    logic busy, rd;
    assign busy = (state_q == ST_PROG) || (state_q == ST_ERASE);
    assign rd   = rd_stb && !ce_n && !oe_n;

    a_r6_rb_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        rb_pull_low |-> !ce_n);

    a_r10_rb_off_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!rb_pull_low && !dq_oe));

    a_r4_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd) |=> (tgl_q != $past(tgl_q)));

    a_r5_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && rd) |=> $stable(tgl_q));

    a_r7_start_enters_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_start) |=> busy);

    a_r8_busy_to_recov: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || state_q == ST_RECOV));

    a_r9_recov_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOV) |=> !busy);

    a_r11_oe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ce_n && !oe_n));

    a_r11_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));

    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dq_oe) |-> (dq_out[5:0] == '0));
endmodule

bind flash_wstat flash_wstat_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_start    (op_start),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .rd_stb      (rd_stb),
    .state_q     (state_q),
    .tgl_q       (tgl_q),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .rb_pull_low (rb_pull_low)
);

// File: tb/flash_wstat_tb.sv
module flash_wstat_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 6;
    localparam int E  = 10;
    localparam int RC = 3;

    logic        clk, rst_n, op_start, op_is_erase, ce_n, oe_n, rd_stb;
    logic [15:0] op_word, arr_data, dq_out;
    logic        dq_oe, rb_pull_low;

    flash_wstat #(.DW(16), .PROG_CYC(P), .ERASE_CYC(E), .RECOV_CYC(RC)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
        .op_word(op_word), .ce_n(ce_n), .oe_n(oe_n), .rd_stb(rd_stb),
        .arr_data(arr_data), .dq_out(dq_out), .dq_oe(dq_oe), .rb_pull_low(rb_pull_low)
    );

    typedef struct {
        string       req;
        logic [15:0] dq;
        logic        oe;
        logic        rb;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic exp_tgl = 1'b0;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string req, logic [15:0] dq, logic oe, logic rb);
        exp_t e;
        e.req = req; e.dq = dq; e.oe = oe; e.rb = rb;
        sb.push_back(e);
    endtask

    function automatic logic [15:0] stat(logic b7, logic b6);
        logic [15:0] v;
        v = '0; v[7] = b7; v[6] = b6;
        return v;
    endfunction

    // Monitor: pops expectations and compares away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (dq_out !== e.dq || dq_oe !== e.oe || rb_pull_low !== e.rb) begin
                n_fail++;
                $display("FAIL %s: dq=%h oe=%b rb=%b expected dq=%h oe=%b rb=%b",
                         e.req, dq_out, dq_oe, rb_pull_low, e.dq, e.oe, e.rb);
            end
        end
    end

    // One full operation with reads, ignored starts and a ce_n-high cycle
    task automatic run_op(logic erase, logic [15:0] word);
        int n;
        logic b7busy, b7done;
        n = erase ? E : P;
        b7busy = erase ? 1'b0 : ~word[7];
        b7done = erase ? 1'b1 : word[7];
        op_start = 1'b1; op_is_erase = erase; op_word = word;
        cyc();
        op_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            ce_n     = (i == 3);
            rd_stb   = (i % 2 == 0) || (i == n - 1);
            op_start = (i == 2);                 // R9: ignored while busy
            if (ce_n)
                expect_out("R6", 16'h0000, 1'b0, 1'b0);
            else
                expect_out(erase ? "R3" : "R2", stat(b7busy, exp_tgl), 1'b1, 1'b1);
            cyc();
            if (rd_stb && !ce_n) exp_tgl = ~exp_tgl; // R4 model
        end
        ce_n = 1'b0; rd_stb = 1'b0; op_start = 1'b0;
        for (int i = 0; i < RC; i++) begin
            rd_stb   = (i == 0);                 // R5: read after completion does not flip
            op_start = (i == RC - 1);            // R9: start on last recovery cycle
            expect_out("R5", stat(b7done, exp_tgl), 1'b1, 1'b0);
            cyc();
        end
        rd_stb = 1'b0; op_start = 1'b0;
        expect_out("R8", arr_data, 1'b1, 1'b0);
        cyc();
        expect_out("R9", arr_data, 1'b1, 1'b0);
        cyc();
    endtask

    initial begin
        rst_n = 1'b0; op_start = 1'b0; op_is_erase = 1'b0; op_word = '0;
        ce_n = 1'b0; oe_n = 1'b0; rd_stb = 1'b0; arr_data = 16'hA5C3;
        cyc();
        expect_out("R1", 16'h0000, 1'b0, 1'b0);
        cyc();
        rst_n = 1'b1;
        cyc();
        expect_out("R1", 16'hA5C3, 1'b1, 1'b0);
        cyc();
        oe_n = 1'b1;
        expect_out("R11", 16'h0000, 1'b0, 1'b0);
        cyc();
        oe_n = 1'b0;

        run_op(1'b0, 16'h1234);   // program, bit 7 = 0
        run_op(1'b1, 16'h0000);   // erase
        arr_data = 16'h3C5A;
        run_op(1'b0, 16'h00FF);   // program, bit 7 = 1

        // R10: abort mid-operation
        op_start = 1'b1; op_is_erase = 1'b1;
        cyc();
        op_start = 1'b0; rd_stb = 1'b1;
        expect_out("R10", stat(1'b0, exp_tgl), 1'b1, 1'b1);
        cyc();
        rd_stb = 1'b0;
        rst_n = 1'b0;
        exp_tgl = 1'b0;
        expect_out("R10", 16'h0000, 1'b0, 1'b0);
        cyc();
        rst_n = 1'b1;
        cyc();
        expect_out("R10", 16'h3C5A, 1'b1, 1'b0);
        cyc();
        // R4: toggle cleared by reset, next operation starts from 0
        op_start = 1'b1; op_is_erase = 1'b0; op_word = 16'h0000;
        cyc();
        op_start = 1'b0;
        expect_out("R4", stat(1'b1, 1'b0), 1'b1, 1'b1);
        cyc();
        cyc();

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule